// File: doc/BRIEF.md
# Prioritized Interrupt Event Controller

This block gathers a set of single-cycle event pulses from peripheral logic into a vector of sticky raw flags. A per-source enable mask selects which flags may interrupt the processor. The controller presents the masked flags, a fixed-priority index naming the most urgent enabled flag, and one registered interrupt line. Software reaches it through a small register port. Through that port it reads the index, reads and writes the mask and the mode, reads raw and masked status, and issues write-one set and clear strobes.

Reading the index from the processor acknowledges the reported event: its raw flag clears and the next read reports the next pending event. A read tagged as coming from a debugger returns the same index without side effects. A mode field picks how the flags behave. In disabled mode, hardware pulses are ignored. In software mode, flags stay until cleared. In hardware mode, each flag drops by itself one cycle after it is set.

Top module: `irq_evt_ctrl`

## Requirements
- R1: The index reads 0 when no flag is both raw-set and enabled; otherwise it reads k+1, where k is the lowest bit position set in the masked status (bit 0 is most urgent and reports 1).
- R2: The masked status always equals the bitwise AND of the raw flags and the mask.
- R3: A processor read of the index (select 0, debug tag low) clears the raw flag it reports on the next clock edge, so successive reads walk the pending events in ascending bit order and then report 0.
- R4: A read of the index with the debug tag high returns the index and leaves every raw flag unchanged.
- R5: Writing the set strobe (select 4) sets each raw flag whose data bit is 1; bits written as 0 leave their flags unchanged.
- R6: Writing the clear strobe (select 5) clears each raw flag whose data bit is 1, also when its mask bit is 0; bits written as 0 leave their flags unchanged.
- R7: Event pulses latch into the raw flags whatever the mask holds; a masked-off flag appears in raw status but not in the index or the interrupt line.
- R8: The mode register (select 6) resets to 1 (software clear). Code 0 ignores event pulses and holds the interrupt line low. Code 2 clears every raw flag one cycle after it was set unless it is set again. Code 3 behaves as code 1.
- R9: When an event pulse or a set strobe hits a bit in the same cycle as a clear strobe or acknowledge on it, the flag ends up set.
- R10: The interrupt line is a register that goes high one clock after the masked status becomes non-zero, and low one clock after it returns to zero.
- R11: Port selects are 0 index, 1 mask, 2 raw status, 3 masked status, 4 set, 5 clear, 6 mode. The mask and the mode read back what was written. After reset, the raw flags, mask, index and interrupt line are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | NUM_SRC | Event pulses, one per source |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect on index only) |
| reg_dbg | input | 1 | Marks the read as a debugger access |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for the selected register, combinational |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds the controller with NUM_SRC = 5. At that width, every pairing of 32 raw patterns with 32 masks is reachable, 1024 cases in all. Each case is checked for index and masked status against values computed arithmetically. Directed sequences at the same width cover the acknowledge walk, debugger reads, set and clear strobes, all four mode codes, collisions between setting and clearing, and the one-cycle lag of the interrupt line.

// File: rtl/iec_pkg.sv
// Shared encodings for the interrupt event controller.
package iec_pkg;
    typedef enum logic [2:0] {
        SEL_IDX   = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_RAW   = 3'd2,
        SEL_MSKST = 3'd3,
        SEL_SET   = 3'd4,
        SEL_CLR   = 3'd5,
        SEL_MODE  = 3'd6
    } sel_e;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_SW  = 2'd1,
        MODE_HW  = 2'd2,
        MODE_ALT = 2'd3
    } mode_e;
endpackage

// File: rtl/iec_prio_enc.sv
// Fixed-priority encoder: lowest set bit wins.
// Assumes NUM_SRC >= 1; the index is position+1, or 0 when nothing is set.
module iec_prio_enc #(
    parameter int NUM_SRC = 9,
    localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] masked,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] grant
);
    // Isolate the lowest set bit as a one-hot grant.
    assign grant = masked & (~masked + NUM_SRC'(1));

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (masked[i]) idx = IDX_W'(i + 1);
        end
    end
endmodule

// File: rtl/iec_flag_bank.sv
// Sticky raw flags, one register per source.
// Setting terms take precedence over all clearing terms in the same cycle.
module iec_flag_bank #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               evt_en,
    input  logic [NUM_SRC-1:0] set_wr,
    input  logic [NUM_SRC-1:0] clr_wr,
    input  logic [NUM_SRC-1:0] ack_oh,
    input  logic               auto_clr,
    output logic [NUM_SRC-1:0] raw
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic flag_q;
        logic set_i;
        logic clr_i;
        assign set_i = (evt_en & evt_pulse[i]) | set_wr[i];
        assign clr_i = clr_wr[i] | ack_oh[i] | auto_clr;
        // Update one flag: set wins, else clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set_i | (flag_q & ~clr_i);
        end
        assign raw[i] = flag_q;
    end
endmodule

// File: rtl/iec_regs.sv
// Register port: decodes selects into strobes, holds mask and mode,
// and muxes read data. Assumes NUM_SRC >= 2 so the mode fits the data bus.
module iec_regs #(
    parameter int NUM_SRC = 9,
    localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_dbg,
    input  logic [NUM_SRC-1:0] reg_wdata,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] masked,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [1:0]         mode_q,
    output logic [NUM_SRC-1:0] set_wr,
    output logic [NUM_SRC-1:0] clr_wr,
    output logic               ack_req,
    output logic [NUM_SRC-1:0] reg_rdata
);
    import iec_pkg::*;

    sel_e sel;
    assign sel = sel_e'(reg_sel);

    // Write-one strobes and processor acknowledge.
    assign set_wr  = (reg_wr && sel == SEL_SET) ? reg_wdata : '0;
    assign clr_wr  = (reg_wr && sel == SEL_CLR) ? reg_wdata : '0;
    assign ack_req = reg_rd && !reg_dbg && sel == SEL_IDX;

    // Mask and mode storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= MODE_SW;
        end else if (reg_wr) begin
            if (sel == SEL_MASK) mask_q <= reg_wdata;
            if (sel == SEL_MODE) mode_q <= reg_wdata[1:0];
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (sel)
            SEL_IDX:   reg_rdata = NUM_SRC'(idx);
            SEL_MASK:  reg_rdata = mask_q;
            SEL_RAW:   reg_rdata = raw;
            SEL_MSKST: reg_rdata = masked;
            SEL_MODE:  reg_rdata = NUM_SRC'(mode_q);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_evt_ctrl.sv
// Top of the prioritized interrupt event controller.
// Assumes single-cycle event pulses and one register access per cycle.
module irq_evt_ctrl #(
    parameter int NUM_SRC = 9,
    localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic [2:0]         reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_dbg,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq
);
    import iec_pkg::*;

    logic [NUM_SRC-1:0] raw, masked, mask_q, set_wr, clr_wr, grant, ack_oh;
    logic [1:0]         mode_q;
    logic [IDX_W-1:0]   idx;
    logic               ack_req, line_on;

    assign masked  = raw & mask_q;
    assign ack_oh  = ack_req ? grant : '0;
    assign line_on = (mode_q != MODE_OFF);

    iec_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_dbg(reg_dbg), .reg_wdata(reg_wdata),
        .raw(raw), .masked(masked), .idx(idx), .mask_q(mask_q),
        .mode_q(mode_q), .set_wr(set_wr), .clr_wr(clr_wr),
        .ack_req(ack_req), .reg_rdata(reg_rdata)
    );

    iec_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_en(line_on),
        .set_wr(set_wr), .clr_wr(clr_wr), .ack_oh(ack_oh),
        .auto_clr(mode_q == MODE_HW), .raw(raw)
    );

    iec_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .masked(masked), .idx(idx), .grant(grant)
    );

    // Registered combined interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= line_on && (masked != '0);
    end
endmodule

// File: rtl/iec_chk.sv
// Property checker for irq_evt_ctrl, attached by bind.
module iec_chk #(
    parameter int NUM_SRC = 9,
    localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic [NUM_SRC-1:0] raw,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [1:0]         mode_q,
    input logic [IDX_W-1:0]   idx,
    input logic [NUM_SRC-1:0] set_wr,
    input logic [NUM_SRC-1:0] clr_wr,
    input logic [2:0]         reg_sel,
    input logic               reg_rd,
    input logic               reg_dbg,
    input logic               irq
);
    logic [NUM_SRC-1:0] msk, below, lowest;
    assign msk    = raw & mask_q;
    assign lowest = msk & (~msk + NUM_SRC'(1));
    // Bits strictly below the reported position.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) below[i] = ((i + 1) < int'(idx));
    end

    AST_IDX_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (msk == '0) |-> (idx == '0)); // R1
    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0) |-> (((msk >> (idx - 1'b1)) & NUM_SRC'(1)) != '0 && (msk & below) == '0)); // R1
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_dbg && reg_sel == 3'd0 && evt_pulse == '0 && set_wr == '0)
        |=> ((raw & $past(lowest)) == '0)); // R3
    AST_DBG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_dbg && reg_sel == 3'd0 && evt_pulse == '0 && set_wr == '0
         && clr_wr == '0 && mode_q == 2'd1) |=> (raw == $past(raw))); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'd0) |=> ((($past(evt_pulse) | $past(set_wr)) & ~raw) == '0)); // R9
    AST_HW_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd2 && evt_pulse == '0 && set_wr == '0) |=> (raw == '0)); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0) |=> !irq); // R8
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(msk) != '0)); // R10
endmodule

bind irq_evt_ctrl iec_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .raw(raw),
    .mask_q(mask_q), .mode_q(mode_q), .idx(idx), .set_wr(set_wr),
    .clr_wr(clr_wr), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_dbg(reg_dbg), .irq(irq)
);

// File: tb/sim_irq_evt_ctrl.sv
`timescale 1ns/1ps
module sim_irq_evt_ctrl;
    localparam int N = 5;
    localparam logic [N-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_pulse = '0;
    logic [2:0]   reg_sel = '0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0, reg_dbg = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq;
    int           n_run = 0, n_fail = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    irq_evt_ctrl #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_dbg(reg_dbg),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input logic [N-1:0] d);
        @(negedge clk);
        reg_sel = 3'(s); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int s, input bit dbg, output int q);
        @(negedge clk);
        reg_sel = 3'(s); reg_dbg = dbg; reg_rd = 1'b1;
        #1 q = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0; reg_dbg = 1'b0;
    endtask

    function automatic int exp_idx(input int m);
        for (int i = 0; i < N; i++) if (m[i]) return i + 1;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state and select encoding
        rd(2, 1, q); chk("R11 raw after reset", q, 0);
        rd(1, 1, q); chk("R11 mask after reset", q, 0);
        rd(0, 1, q); chk("R11 idx after reset", q, 0);
        chk("R11 irq after reset", int'(irq), 0);
        rd(6, 1, q); chk("R8 mode resets to software", q, 1);
        wr(1, 5'b10101); rd(1, 1, q); chk("R11 mask readback", q, 5'b10101);

        // R1 R2 exhaustive sweep over raw and mask
        for (int m = 0; m < 32; m++) begin
            for (int r = 0; r < 32; r++) begin
                wr(5, ALL); wr(4, N'(r)); wr(1, N'(m));
                rd(0, 1, q); chk("R1 index", q, exp_idx(r & m));
                rd(3, 1, q); chk("R2 masked status", q, r & m);
            end
        end

        // R3 acknowledge walk
        wr(5, ALL); wr(1, ALL); wr(4, 5'b10110);
        rd(0, 0, q); chk("R3 first ack", q, 2);
        rd(0, 0, q); chk("R3 second ack", q, 3);
        rd(0, 0, q); chk("R3 third ack", q, 5);
        rd(0, 0, q); chk("R3 after walk", q, 0);
        rd(2, 1, q); chk("R3 raw empty after walk", q, 0);

        // R4 debug reads have no side effect
        wr(4, 5'b01100);
        rd(0, 1, q); chk("R4 debug read", q, 3);
        rd(0, 1, q); chk("R4 debug reread", q, 3);
        rd(2, 1, q); chk("R4 raw intact", q, 5'b01100);

        // R5 R6 set and clear strobes with mask off
        wr(1, '0); wr(5, ALL); wr(4, ALL);
        wr(5, 5'b00101); rd(2, 1, q); chk("R6 clear with mask off", q, 5'b11010);
        wr(5, '0);       rd(2, 1, q); chk("R6 clear zero no effect", q, 5'b11010);
        wr(4, '0);       rd(2, 1, q); chk("R5 set zero no effect", q, 5'b11010);
        wr(4, 5'b00001); rd(2, 1, q); chk("R5 set one", q, 5'b11011);

        // R7 events latch with mask off, no index, no irq
        wr(5, ALL);
        @(negedge clk); evt_pulse = 5'b01001;
        @(negedge clk); evt_pulse = '0;
        rd(2, 1, q); chk("R7 raw latched under mask 0", q, 5'b01001);
        rd(0, 1, q); chk("R7 index ignores masked-off", q, 0);
        chk("R7 irq low", int'(irq), 0);

        // R9 event and clear strobe in the same cycle
        @(negedge clk);
        evt_pulse = 5'b00100; reg_sel = 3'd5; reg_wdata = ALL; reg_wr = 1'b1;
        @(negedge clk); evt_pulse = '0; reg_wr = 1'b0;
        rd(2, 1, q); chk("R9 set wins over clear", q, 5'b00100);

        // R10 irq lags masked status by one clock
        wr(5, ALL); wr(1, 5'b00001);
        @(negedge clk); chk("R10 irq idle", int'(irq), 0);
        wr(4, 5'b00001);
        chk("R10 irq not yet", int'(irq), 0);
        @(negedge clk); chk("R10 irq raised", int'(irq), 1);
        wr(5, 5'b00001);
        chk("R10 irq still high", int'(irq), 1);
        @(negedge clk); chk("R10 irq dropped", int'(irq), 0);

        // R8 disabled mode
        wr(6, 2'd0); rd(6, 1, q); chk("R8 mode readback 0", q, 0);
        wr(1, ALL);
        @(negedge clk); evt_pulse = ALL;
        @(negedge clk); evt_pulse = '0;
        rd(2, 1, q); chk("R8 off ignores events", q, 0);
        wr(4, 5'b00010);
        @(negedge clk); @(negedge clk);
        chk("R8 off holds irq low", int'(irq), 0);
        wr(5, ALL);

        // R8 hardware auto-clear
        wr(6, 2'd2);
        @(negedge clk); evt_pulse = 5'b00100; reg_sel = 3'd2;
        @(negedge clk); evt_pulse = '0;
        #1 chk("R8 hw flag visible", int'(reg_rdata), 5'b00100);
        @(negedge clk);
        #1 chk("R8 hw flag auto-cleared", int'(reg_rdata), 0);

        // R8 code 3 acts as software mode
        wr(6, 2'd3); rd(6, 1, q); chk("R8 mode readback 3", q, 3);
        @(negedge clk); evt_pulse = 5'b10000;
        @(negedge clk); evt_pulse = '0;
        @(negedge clk); @(negedge clk);
        rd(2, 1, q); chk("R8 code 3 keeps flag", q, 5'b10000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule